// File: doc/BRIEF.md
# Serial PLL Configuration Shifter

This block loads a 56-bit programming word for an external frequency synthesizer and sends it out one bit at a time on a serial data line. The word is seven bytes. The bytes go out in rising index order, and each byte goes out most-significant bit first. Every bit stays on the data line for a fixed number of system clocks. A one-cycle strobe inside each bit period tells the synthesizer when to sample. While the 56th bit is on the line, a hold line is raised alongside it so that the synthesizer latches the complete setting.

A host pulses `start` with the word present on `cfg_word`. The block reports `busy` for the whole transfer and gives a one-cycle `done` pulse when the transfer ends. A system that uses it should blank the pixel output before it starts a transfer. It should restore the output only after the display timing has been reloaded once `done` has been seen.

Top module: `pll_cfg_shifter`

## Requirements
- R1: After reset, `ser_data`, `ser_strobe`, `ser_hold`, `busy` and `done` are all low.
- R2: Byte i of the word is `cfg_word[8i+7:8i]`. Byte 0 is sent first and byte 6 last.
- R3: Within a byte, bit 7 is sent first and bit 0 last.
- R4: Each serial bit occupies exactly BIT_CLKS consecutive cycles. `ser_data` does not change inside that period.
- R5: `ser_strobe` pulses high for one cycle in each bit period, at cycle BIT_CLKS/2 of the period (counting from 0). A transfer has exactly 56 strobes.
- R6: `ser_hold` is high during the whole period of the 56th bit and low at all other times.
- R7: `busy` rises in the cycle after an accepted `start` and stays high for exactly 56*BIT_CLKS cycles.
- R8: A `start` pulse while `busy` is high is ignored. The transfer continues unchanged and no second transfer follows.
- R9: `done` is high for exactly one cycle, in the first cycle after `busy` falls, with `ser_hold` already low.
- R10: `cfg_word` is sampled only when a start is accepted. Changes to it during a transfer do not alter the transmitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| cfg_word | input | 56 | Programming word, byte i in bits 8i+7..8i |
| ser_data | output | 1 | Serial data bit |
| ser_strobe | output | 1 | One-cycle sample strobe per bit |
| ser_hold | output | 1 | Latch flag, high with the final bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with BIT_CLKS = 3. With this odd value the strobe falls in the middle cycle of the period, so every bit has both a setup cycle and a hold cycle around the strobe. The small value also keeps each transfer at 168 cycles, which leaves room for several complete words. These include a single-bit walk that checks the bit order, words with distinct bytes that check the byte order, and transfers that are disturbed by a second start or by a change to the word partway through.

// File: rtl/pll_cfg_shifter.sv
module pll_cfg_shifter #(
  parameter int BIT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [55:0] cfg_word,
  output logic        ser_data,
  output logic        ser_strobe,
  output logic        ser_hold,
  output logic        busy,
  output logic        done
);
  localparam int NBYTES = 7;
  localparam int NBITS  = NBYTES * 8;
  localparam int TW     = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;

  logic [NBITS-1:0] order, sh;
  logic [TW-1:0]    tick;
  logic [5:0]       idx;
  logic             last_tick, last_bit;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign order[NBITS-1-(8*i+j)] = cfg_word[8*i+7-j];
    end
  end

  assign last_tick  = tick == TW'(BIT_CLKS-1);
  assign last_bit   = idx == 6'(NBITS-1);
  assign ser_data   = busy & sh[NBITS-1];
  assign ser_strobe = busy && tick == TW'(BIT_CLKS/2);
  assign ser_hold   = busy && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sh   <= '0;
      tick <= '0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= order;
          idx  <= '0;
          tick <= '0;
        end
      end else if (last_tick) begin
        tick <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 6'd1;
          sh  <= sh << 1;
        end
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(last_tick)) |-> $stable(ser_data));
  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |=> !ser_strobe);
  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_hold) |-> done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_tick) |=> (busy && $stable(idx)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !ser_hold && $past(busy)));
endmodule

// File: tb/sim_pll_cfg_shifter.sv
module sim_pll_cfg_shifter;
  localparam int B = 3;
  localparam int NB = 56;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [55:0] cfg_word = '0;
  logic ser_data, ser_strobe, ser_hold, busy, done;
  int tests = 0, fails = 0;

  int  bcnt, ncap, stab_err, strb_err, hold_err, done_cnt, done_bad;
  logic prev_d;
  logic cap [0:NB-1];

  always #4 clk = ~clk;

  pll_cfg_shifter #(.BIT_CLKS(B)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .ser_data(ser_data), .ser_strobe(ser_strobe), .ser_hold(ser_hold),
    .busy(busy), .done(done));

  always @(negedge clk) begin
    if (rst_n && busy) begin
      if ((bcnt % B) != 0 && ser_data !== prev_d) stab_err++;
      if (ser_strobe !== ((bcnt % B) == B/2)) strb_err++;
      if (ser_hold !== ((bcnt / B) == NB-1)) hold_err++;
      if (ser_strobe && ncap < NB) begin cap[ncap] = ser_data; ncap++; end
      else if (ser_strobe) ncap++;
      prev_d = ser_data;
      bcnt++;
    end else if (rst_n && ser_hold) hold_err++;
    if (rst_n && done) begin
      done_cnt++;
      if (busy || ser_hold) done_bad++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [55:0] w, input int k);
    return w[8*(k/8) + 7 - (k%8)];
  endfunction

  task automatic run_word(input logic [55:0] w, input bit poke_start, input bit poke_word);
    int mism;
    bcnt = 0; ncap = 0; stab_err = 0; strb_err = 0; hold_err = 0;
    done_cnt = 0; done_bad = 0;
    @(negedge clk); cfg_word = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_word) cfg_word = ~w;
    repeat (20) @(negedge clk);
    if (poke_start) begin
      cfg_word = ~w; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < NB*B + 40 && done_cnt == 0; t++) @(negedge clk);
    repeat (B*4) @(negedge clk);
    mism = 0;
    for (int k = 0; k < NB; k++) if (cap[k] !== exp_bit(w, k)) mism++;
    check(mism == 0, "R2 bit stream", mism, 0);
    check(ncap == NB, "R5 strobe count", ncap, NB);
    check(strb_err == 0, "R5 strobe position", strb_err, 0);
    check(stab_err == 0, "R4 data stable in period", stab_err, 0);
    check(hold_err == 0, "R6 hold window", hold_err, 0);
    check(bcnt == NB*B, "R7 busy length", bcnt, NB*B);
    check(done_cnt == 1 && done_bad == 0, "R9 done pulse", done_cnt, 1);
    check(busy == 1'b0, "R8 no retrigger", busy, 0);
  endtask

  task automatic t_reset;
    check(ser_data == 0 && ser_strobe == 0 && ser_hold == 0 && busy == 0 && done == 0,
          "R1 reset outputs", {ser_data, ser_strobe, ser_hold, busy, done}, 0);
  endtask

  task automatic t_bytes;
    run_word(56'h66_55_44_33_22_11_F0, 1'b0, 1'b0);
    check(cap[0] == 1'b1 && cap[4] == 1'b0 && cap[NB-1] == 1'b0, "R2 byte0 first",
          {cap[0], cap[4]}, 2);
  endtask

  task automatic t_msb;
    run_word(56'h01_00_00_00_00_00_80, 1'b0, 1'b0);
    check(cap[0] == 1'b1 && cap[1] == 1'b0, "R3 msb first", cap[0], 1);
    check(cap[NB-1] == 1'b1 && cap[NB-8] == 1'b0, "R3 last byte lsb last", cap[NB-1], 1);
  endtask

  task automatic t_ones;
    run_word('1, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start;
    run_word(56'hA5_3C_96_0F_E1_7B_2D, 1'b1, 1'b0);
    check(done_cnt == 1, "R8 second start ignored", done_cnt, 1);
  endtask

  task automatic t_word_change;
    run_word(56'h12_34_56_78_9A_BC_DE, 1'b0, 1'b1);
    check(cap[0] == exp_bit(56'h12_34_56_78_9A_BC_DE, 0), "R10 word latched",
          cap[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_msb();
    t_ones();
    t_busy_start();
    t_word_change();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule